// File: doc/BRIEF.md
# CAN Fault-Confinement State Monitor

This block keeps the transmit and receive error counters of a CAN node and turns them into one of four fault-confinement states: error-active, warning, error-passive or bus-off. The protocol engine sends it one-cycle pulses. One pulse marks each detected error and one marks each good frame, for each direction. A separate pulse requests recovery after bus-off. The block does no frame-level error detection itself.

Both counters are presented in one packed counter word. A status word carries a one-hot state flag group and a group of sticky frame-error flags. The frame-error flags are latched from pulses supplied by the protocol engine and are cleared by a status-read strobe. Interrupt enables sit in the same bit positions as the status word and are changed through separate set and clear vectors. A one-cycle change pulse marks every change of the resolved state. The interrupt output combines the enabled frame-error flags with the change pulse, gated by the enable of the newly entered state.

Top module: `can_conf_monitor`

## Requirements
- R1: The counter word holds the receive count in bits 7:0 and the transmit count in bits 23:16. Each field reads 255 when its counter is above 255, and every other bit reads 0.
- R2: The receive counter rises by 1 on an error pulse and falls by 1 on a good-frame pulse. When both pulses arrive in the same cycle it changes by their net. It stays between 0 and 255.
- R3: The transmit counter rises by 8 on an error pulse and falls by 1 on a good-frame pulse. When both arrive together it moves by the net +7. It never goes below 0.
- R4: The state is resolved with strict precedence. It is bus-off if the transmit count is 256 or more. Otherwise it is error-passive if either count is 128 or more. Otherwise it is warning if either count is 96 or more. Otherwise it is error-active.
- R5: The status word shows exactly one state flag: error-active at bit 16, warning at bit 17, error-passive at bit 18, bus-off at bit 19. Bits 15:0, 23:20 and 31:29 read 0.
- R6: While the node is bus-off, all counter pulses are ignored and both counters hold their values.
- R7: A recovery pulse clears both counters in the next cycle, which returns the state to error-active. It overrides any counter pulse in the same cycle.
- R8: The change output is high for exactly the one cycle after the clock edge on which the resolved state took a new value.
- R9: Frame-error pulses on input bits 0..4 (CRC, stuffing, acknowledge, form, bit) set sticky status bits 24..28. A status-read strobe clears them, but an error pulse in the same cycle as the strobe is kept.
- R10: The interrupt enable word has bits only at status positions 16..19 and 24..28. The set vector wins over the clear vector, and all other bits read 0.
- R11: The interrupt output is high while any enabled frame-error bit is set. It is also high during a change pulse whose newly entered state has its flag enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_err_inc | input | 1 | Transmit error pulse |
| tx_ok_dec | input | 1 | Good transmitted frame pulse |
| rx_err_inc | input | 1 | Receive error pulse |
| rx_ok_dec | input | 1 | Good received frame pulse |
| recover | input | 1 | Bus-off recovery pulse |
| frame_err | input | 5 | Frame error pulses: CRC, stuffing, acknowledge, form, bit |
| stat_rd | input | 1 | Status read strobe, clears frame-error flags |
| ie_set | input | 32 | Interrupt enable set vector |
| ie_clr | input | 32 | Interrupt enable clear vector |
| cnt_word | output | 32 | Packed counter word |
| status | output | 32 | State flags and frame-error flags |
| ie_mask | output | 32 | Current interrupt enables |
| state_chg | output | 1 | One-cycle state change pulse |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with its default parameters: 9-bit counters, steps of 8 and 1, and thresholds 96, 128 and 256. With these values a full sweep of each counter, from zero to its ceiling and back to its floor, takes only a few hundred cycles. The sweeps cross every threshold in both directions, and they push each counter against its saturation limit. The bench also reaches mixed counter values where the precedence rule decides the state, and it covers bus-off entry, holding and recovery.

// File: rtl/can_conf_pkg.sv
package can_conf_pkg;

    typedef enum logic [1:0] {
        CS_ACTIVE  = 2'd0,
        CS_WARN    = 2'd1,
        CS_PASSIVE = 2'd2,
        CS_BUSOFF  = 2'd3
    } conf_state_e;

    localparam int REG_W        = 32;
    localparam int FIELD_W      = 8;
    localparam int RX_FIELD_LSB = 0;
    localparam int TX_FIELD_LSB = 16;
    localparam int FLAG_LSB     = 16;
    localparam int NUM_FLAGS    = 4;
    localparam int FERR_LSB     = 24;
    localparam int NUM_FERR     = 5;

    localparam logic [REG_W-1:0] FLAG_MASK = REG_W'(((1 << NUM_FLAGS) - 1) << FLAG_LSB);
    localparam logic [REG_W-1:0] FERR_MASK = REG_W'(((1 << NUM_FERR) - 1) << FERR_LSB);
    localparam logic [REG_W-1:0] IE_IMPL   = FLAG_MASK | FERR_MASK;

endpackage

// File: rtl/can_err_counter.sv
module can_err_counter #(
    parameter int W    = 9,
    parameter int STEP = 1,
    parameter int MAX  = 255
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc,
    input  logic         dec,
    input  logic         clr,
    input  logic         hold,
    output logic [W-1:0] cnt
);
    localparam int SW = W + 2;

    typedef struct packed {
        logic [W-1:0] cnt;
    } cnt_st_t;

    cnt_st_t st_d, st_q;
    logic [SW-1:0] sum;

    always_comb begin
        st_d = st_q;
        sum  = SW'(st_q.cnt) + (inc ? SW'(STEP) : SW'(0));
        if (dec && sum != '0) begin
            sum = sum - SW'(1);
        end
        if (sum > SW'(MAX)) begin
            sum = SW'(MAX);
        end
        if (clr) begin
            st_d.cnt = '0;
        end else if (!hold) begin
            st_d.cnt = sum[W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt = st_q.cnt;

    // R2 ceiling: saturated counter does not wrap on a lone increment
    a_r2_sat_ceiling: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == W'(MAX) && inc && !dec && !clr) |=> (cnt == W'(MAX)));

    // R3 floor: counter at zero stays at zero on a lone decrement
    a_r3_floor: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == '0 && dec && !inc && !clr && !hold) |=> (cnt == '0));

endmodule

// File: rtl/can_conf_resolver.sv
module can_conf_resolver
    import can_conf_pkg::*;
#(
    parameter int W        = 9,
    parameter int WARN_LIM = 96,
    parameter int PASS_LIM = 128,
    parameter int BOFF_LIM = 256
) (
    input  logic [W-1:0]         tx_cnt,
    input  logic [W-1:0]         rx_cnt,
    output conf_state_e          state,
    output logic [NUM_FLAGS-1:0] flags
);
    logic boff_hit, pass_hit, warn_hit;

    always_comb begin
        boff_hit = (tx_cnt >= W'(BOFF_LIM));
        pass_hit = (tx_cnt >= W'(PASS_LIM)) || (rx_cnt >= W'(PASS_LIM));
        warn_hit = (tx_cnt >= W'(WARN_LIM)) || (rx_cnt >= W'(WARN_LIM));
        if (boff_hit) begin
            state = CS_BUSOFF;
        end else if (pass_hit) begin
            state = CS_PASSIVE;
        end else if (warn_hit) begin
            state = CS_WARN;
        end else begin
            state = CS_ACTIVE;
        end
        flags = NUM_FLAGS'(1) << state;
    end

endmodule

// File: rtl/can_flag_regs.sv
module can_flag_regs
    import can_conf_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_FERR-1:0] ferr_in,
    input  logic                rd_clr,
    input  logic [REG_W-1:0]    ie_set,
    input  logic [REG_W-1:0]    ie_clr,
    output logic [NUM_FERR-1:0] ferr,
    output logic [REG_W-1:0]    ie
);
    typedef struct packed {
        logic [NUM_FERR-1:0] ferr;
        logic [REG_W-1:0]    ie;
    } flag_st_t;

    flag_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.ferr = (rd_clr ? '0 : st_q.ferr) | ferr_in;
        st_d.ie   = ((st_q.ie & ~ie_clr) | ie_set) & IE_IMPL;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ferr = st_q.ferr;
    assign ie   = st_q.ie;

    // R9 pulses are latched even alongside a read
    a_r9_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (ferr_in != '0) |=> ((ferr & $past(ferr_in)) == $past(ferr_in)));

    // R9 read with no new error empties the flags
    a_r9_rd_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_clr && ferr_in == '0) |=> (ferr == '0));

    // R10 set wins over clear
    a_r10_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        ((ie_set & IE_IMPL) != '0) |=> ((ie & $past(ie_set & IE_IMPL)) == $past(ie_set & IE_IMPL)));

    // R10 unimplemented enable bits stay zero
    a_r10_impl_only: assert property (@(posedge clk) disable iff (!rst_n)
        (ie & ~IE_IMPL) == '0);

endmodule

// File: rtl/can_conf_monitor.sv
module can_conf_monitor
    import can_conf_pkg::*;
#(
    parameter int CNT_W    = 9,
    parameter int TX_STEP  = 8,
    parameter int RX_STEP  = 1,
    parameter int RX_MAX   = 255,
    parameter int WARN_LIM = 96,
    parameter int PASS_LIM = 128,
    parameter int BOFF_LIM = 256
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        tx_err_inc,
    input  logic        tx_ok_dec,
    input  logic        rx_err_inc,
    input  logic        rx_ok_dec,
    input  logic        recover,
    input  logic [4:0]  frame_err,
    input  logic        stat_rd,
    input  logic [31:0] ie_set,
    input  logic [31:0] ie_clr,
    output logic [31:0] cnt_word,
    output logic [31:0] status,
    output logic [31:0] ie_mask,
    output logic        state_chg,
    output logic        irq
);
    localparam int FIELD_MAX = (1 << FIELD_W) - 1;

    typedef struct packed {
        conf_state_e prev;
    } mon_st_t;

    mon_st_t st_d, st_q;

    logic [CNT_W-1:0]     tx_cnt, rx_cnt;
    conf_state_e          state_now;
    logic [NUM_FLAGS-1:0] flags;
    logic [NUM_FERR-1:0]  ferr;
    logic                 in_boff;
    logic [FIELD_W-1:0]   tx_field, rx_field;

    assign in_boff = (state_now == CS_BUSOFF);

    can_err_counter #(.W(CNT_W), .STEP(TX_STEP), .MAX(BOFF_LIM)) u_tx_cnt (
        .clk  (clk),
        .rst_n(rst_n),
        .inc  (tx_err_inc),
        .dec  (tx_ok_dec),
        .clr  (recover),
        .hold (in_boff),
        .cnt  (tx_cnt)
    );

    can_err_counter #(.W(CNT_W), .STEP(RX_STEP), .MAX(RX_MAX)) u_rx_cnt (
        .clk  (clk),
        .rst_n(rst_n),
        .inc  (rx_err_inc),
        .dec  (rx_ok_dec),
        .clr  (recover),
        .hold (in_boff),
        .cnt  (rx_cnt)
    );

    can_conf_resolver #(
        .W(CNT_W), .WARN_LIM(WARN_LIM), .PASS_LIM(PASS_LIM), .BOFF_LIM(BOFF_LIM)
    ) u_resolve (
        .tx_cnt(tx_cnt),
        .rx_cnt(rx_cnt),
        .state (state_now),
        .flags (flags)
    );

    can_flag_regs u_flags (
        .clk    (clk),
        .rst_n  (rst_n),
        .ferr_in(frame_err),
        .rd_clr (stat_rd),
        .ie_set (ie_set),
        .ie_clr (ie_clr),
        .ferr   (ferr),
        .ie     (ie_mask)
    );

    always_comb begin
        st_d      = st_q;
        st_d.prev = state_now;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{prev: CS_ACTIVE};
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        tx_field = (tx_cnt > CNT_W'(FIELD_MAX)) ? FIELD_W'(FIELD_MAX) : tx_cnt[FIELD_W-1:0];
        rx_field = (rx_cnt > CNT_W'(FIELD_MAX)) ? FIELD_W'(FIELD_MAX) : rx_cnt[FIELD_W-1:0];
        cnt_word = '0;
        cnt_word[RX_FIELD_LSB +: FIELD_W] = rx_field;
        cnt_word[TX_FIELD_LSB +: FIELD_W] = tx_field;
        status = '0;
        status[FLAG_LSB +: NUM_FLAGS] = flags;
        status[FERR_LSB +: NUM_FERR]  = ferr;
        state_chg = (state_now != st_q.prev);
        irq = ((ferr & ie_mask[FERR_LSB +: NUM_FERR]) != '0)
            || (state_chg && ((flags & ie_mask[FLAG_LSB +: NUM_FLAGS]) != '0));
    end

    // R6 counters frozen during bus-off
    a_r6_boff_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (in_boff && !recover) |=> ($stable(tx_cnt) && $stable(rx_cnt)));

    // R7 recovery clears both counters
    a_r7_recover: assert property (@(posedge clk) disable iff (!rst_n)
        recover |=> (cnt_word == '0 && status[FLAG_LSB]));

    // R5 exactly one state flag
    a_r5_one_flag: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(status[FLAG_LSB +: NUM_FLAGS]) == 1);

    // R8 pulse only when the flag group moved
    a_r8_chg_moved: assert property (@(posedge clk) disable iff (!rst_n)
        state_chg |-> (status[FLAG_LSB +: NUM_FLAGS] != $past(status[FLAG_LSB +: NUM_FLAGS])));

    // R4 bus-off threshold reached shows bus-off flag
    a_r4_boff_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_cnt >= CNT_W'(BOFF_LIM)) |-> status[FLAG_LSB + 3]);

endmodule

// File: tb/test_can_conf_monitor.sv
module test_can_conf_monitor;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tx_err_inc = 0, tx_ok_dec = 0, rx_err_inc = 0, rx_ok_dec = 0, recover = 0;
    logic [4:0]  frame_err = '0;
    logic        stat_rd = 0;
    logic [31:0] ie_set = '0, ie_clr = '0;
    logic [31:0] cnt_word, status, ie_mask;
    logic        state_chg, irq;

    int errors = 0;
    int checks = 0;
    int mtx = 0, mrx = 0;
    logic [4:0]  mferr = '0;
    logic [31:0] mie = '0;
    localparam logic [31:0] IMPL = 32'h1F0F_0000;

    always #5 clk = ~clk;

    can_conf_monitor i_can_conf_monitor (
        .clk(clk), .rst_n(rst_n),
        .tx_err_inc(tx_err_inc), .tx_ok_dec(tx_ok_dec),
        .rx_err_inc(rx_err_inc), .rx_ok_dec(rx_ok_dec),
        .recover(recover), .frame_err(frame_err), .stat_rd(stat_rd),
        .ie_set(ie_set), .ie_clr(ie_clr),
        .cnt_word(cnt_word), .status(status), .ie_mask(ie_mask),
        .state_chg(state_chg), .irq(irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic int clampi(input int v, input int lo, input int hi);
        return (v < lo) ? lo : ((v > hi) ? hi : v);
    endfunction

    function automatic int exp_state();
        if (mtx >= 256) return 3;
        if (mtx >= 128 || mrx >= 128) return 2;
        if (mtx >= 96 || mrx >= 96) return 1;
        return 0;
    endfunction

    task automatic check_all(input logic exp_chg);
        int st;
        logic [31:0] ecnt, estat;
        logic eirq;
        st    = exp_state();
        ecnt  = 32'(clampi(mrx, 0, 255)) | (32'(clampi(mtx, 0, 255)) << 16);
        estat = (32'h1 << (16 + st)) | (32'(mferr) << 24);
        eirq  = ((mferr & mie[28:24]) != '0) || (exp_chg && mie[16 + st]);
        chk("R1/R2/R3/R6/R7 cnt_word", cnt_word, ecnt);
        chk("R4/R5/R9 status", status, estat);
        chk("R10 ie_mask", ie_mask, mie);
        chk("R8 state_chg", 32'(state_chg), 32'(exp_chg));
        chk("R11 irq", 32'(irq), 32'(eirq));
    endtask

    task automatic step(input logic ti, input logic td, input logic ri, input logic rd,
                        input logic rec, input logic [4:0] fe, input logic srd,
                        input logic [31:0] s, input logic [31:0] c);
        int ps;
        ps = exp_state();
        tx_err_inc = ti; tx_ok_dec = td; rx_err_inc = ri; rx_ok_dec = rd;
        recover = rec; frame_err = fe; stat_rd = srd; ie_set = s; ie_clr = c;
        @(negedge clk);
        tx_err_inc = 0; tx_ok_dec = 0; rx_err_inc = 0; rx_ok_dec = 0;
        recover = 0; frame_err = '0; stat_rd = 0; ie_set = '0; ie_clr = '0;
        if (rec) begin
            mtx = 0; mrx = 0;
        end else if (ps != 3) begin
            mtx = clampi(mtx + (ti ? 8 : 0) - (td ? 1 : 0), 0, 256);
            mrx = clampi(mrx + (ri ? 1 : 0) - (rd ? 1 : 0), 0, 255);
        end
        mferr = (srd ? 5'd0 : mferr) | fe;
        mie   = ((mie & ~c) | s) & IMPL;
        check_all(exp_state() != ps);
    endtask

    task automatic cnt_step(input logic ti, input logic td, input logic ri, input logic rd);
        step(ti, td, ri, rd, 1'b0, 5'd0, 1'b0, '0, '0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // reset state: R1 R5 R10 R11
        check_all(1'b0);

        // R10: enable everything including an unimplemented bit
        step(0, 0, 0, 0, 0, '0, 0, 32'hFFFF_FFFF, '0);

        // R2/R4/R8/R11: receive sweep up past saturation
        for (int i = 0; i < 260; i++) cnt_step(0, 0, 1, 0);
        // R2 simultaneous at ceiling and net zero
        cnt_step(0, 0, 1, 1);
        // R2 sweep down past floor
        for (int i = 0; i < 260; i++) cnt_step(0, 0, 0, 1);
        cnt_step(0, 0, 1, 1);

        // R3/R6: transmit sweep into bus-off, extra pulses ignored
        for (int i = 0; i < 34; i++) cnt_step(1, 0, 0, 0);
        for (int i = 0; i < 4; i++) cnt_step(0, 1, 1, 1);
        cnt_step(1, 1, 1, 0);
        // R7 recovery with competing pulses
        step(1, 0, 1, 0, 1, '0, 0, '0, '0);

        // R3 net +7 and floor
        for (int i = 0; i < 20; i++) cnt_step(1, 1, 0, 0);
        for (int i = 0; i < 150; i++) cnt_step(0, 1, 0, 0);

        // R4 precedence: receive passive while transmit only warns
        for (int i = 0; i < 130; i++) cnt_step(0, 0, 1, 0);
        for (int i = 0; i < 12; i++) cnt_step(1, 0, 0, 0);
        for (int i = 0; i < 20; i++) cnt_step(1, 0, 0, 0);
        step(0, 0, 0, 0, 1, '0, 0, '0, '0);

        // R11: disable warning enable, change pulse without irq
        step(0, 0, 0, 0, 0, '0, 0, '0, 32'h0002_0000);
        for (int i = 0; i < 97; i++) cnt_step(0, 0, 1, 0);
        step(0, 0, 0, 0, 1, '0, 0, '0, '0);

        // R9/R11: each frame error bit, then cleared by read
        for (int b = 0; b < 5; b++) begin
            step(0, 0, 0, 0, 0, 5'(1 << b), 0, '0, '0);
            step(0, 0, 0, 0, 0, '0, 1, '0, '0);
        end
        // R9 read with same-cycle error keeps it
        step(0, 0, 0, 0, 0, 5'b00101, 0, '0, '0);
        step(0, 0, 0, 0, 0, 5'b10000, 1, '0, '0);
        // R10/R11 masked frame error: clear enable, irq must drop
        step(0, 0, 0, 0, 0, '0, 0, '0, 32'h1000_0000);
        // R10 set and clear together, set wins
        step(0, 0, 0, 0, 0, '0, 0, 32'h0100_0000, 32'hFFFF_FFFF);
        step(0, 0, 0, 0, 0, '0, 1, '0, '0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule